// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block steps a programmable device from power-up to user operation through four phases: initialization, configuration, start-up and operation. During initialization it holds the shared INIT line low until a power-on delay has run. It asks for the configuration memory to be cleared. It then waits until the wire-ANDed INIT line, the program request and the reset request have all settled high. A master-mode device waits a few extra cycles there.

In configuration it counts configuration clock cycles against a loaded length. It finishes once that length is reached and the end frame has been written. Start-up then releases the I/Os and the internal reset and raises DONE, and after a fixed number of cycles the block enters operation. The abort rules depend on the phase. Program and reset requests and bit errors pull configuration back to initialization. Once start-up has begun, only a program request restarts the device.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in initialization: `init_drv_low`=1, `hdc`=1, `ldc`=0, and `done`, `io_active`, `int_rst_rel`, `cfg_active`, `op_active` are all 0.
- R2: On every entry into initialization, `init_drv_low` stays 1 until `pwr_good` has been high on POR_CYC rising edges, and then drops to 0.
- R3: `mem_clear` is high exactly while `init_drv_low` is high, except when `keep_mem`=1 and a configuration has already finished since `rst_n` was released. In that case it stays 0.
- R4: `init_line`, `prgm_n` and `reset_n` each pass through a two-flop synchronizer. While the sensed `init_line` is low, the block stays in initialization. After the line rises, configuration starts 2+INIT_HI_CYC edges later.
- R5: In slave mode (`master_mode`=0), configuration (`cfg_active`=1) begins on the edge where sensed INIT, PRGM and RESET have all been high for INIT_HI_CYC consecutive edges after the delay.
- R6: In master mode (`master_mode`=1), the block waits MASTER_EXTRA more edges before configuration begins.
- R7: `mode_sel` is captured into `mode_q` on the edge that enters configuration. `mode_q` then holds while `mode_sel` changes.
- R8: On entry to configuration the cycle counter is cleared. It adds one on each edge with `cclk_en`=1 and saturates at `len_count`. The edge after the count equals `len_count` with a `frame_done` pulse already seen moves the block to start-up. A zero length needs only the frame.
- R9: In start-up and operation, `done`, `io_active`, `int_rst_rel` and `ldc` are 1 and `hdc` is 0. Start-up lasts STARTUP_CYC edges, and then `op_active` becomes 1.
- R10: In configuration, a low `prgm_n` or `reset_n` returns the block to initialization three edges after the input falls. Configuration is not re-entered until both are high again.
- R11: `bit_err` high during configuration returns the block to initialization on the next edge.
- R12: In start-up and operation, a low `reset_n` has no effect. A low `prgm_n` returns the block to initialization three edges after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst_n | input | 1 | asynchronous power-on reset, active low |
| pwr_good | input | 1 | supply stable indication |
| init_line | input | 1 | sensed level of the wire-ANDed INIT line |
| prgm_n | input | 1 | program request, active low |
| reset_n | input | 1 | reset request, active low |
| mode_sel | input | MODE_W | configuration mode select lines |
| master_mode | input | 1 | 1 = device sources the configuration clock |
| cclk_en | input | 1 | one configuration clock cycle occurred |
| frame_done | input | 1 | end-of-configuration frame written strobe |
| len_count | input | CNT_W | loaded length count |
| bit_err | input | 1 | configuration bit error detected |
| keep_mem | input | 1 | skip memory clear on reconfiguration |
| init_drv_low | output | 1 | pull the INIT line low |
| hdc | output | 1 | high during initialization and configuration |
| ldc | output | 1 | low during initialization and configuration |
| done | output | 1 | configuration finished |
| io_active | output | 1 | user I/Os enabled |
| int_rst_rel | output | 1 | internal reset released |
| mem_clear | output | 1 | clear configuration memory request |
| cfg_active | output | 1 | configuration phase, data output enabled |
| op_active | output | 1 | operation phase |
| mode_q | output | MODE_W | mode lines latched at configuration entry |

## Verification
The bench counts edges between each stimulus and the output change it causes. An error in synchronizer depth, the INIT high count or the master extension therefore shows up as a count that is off by a few edges, not as a missing event. Completion is driven twice: once with the frame before the length is reached, and once after the counter has been driven past the length. A design that does not saturate the counter never finishes. A design that ignores the frame finishes early. Reset is held low during operation, and a block that aborts on it drops DONE. The program and reset requests are released one at a time, so a design that re-enters configuration when only one of them is high is caught. `mem_clear` is sampled on the first configuration, on reconfiguration and after a power cycle, to check that the skip-clear option applies only to reconfiguration.

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl #(
  parameter int MODE_W       = 3,
  parameter int CNT_W        = 16,
  parameter int POR_CYC      = 8,
  parameter int INIT_HI_CYC  = 2,
  parameter int MASTER_EXTRA = 6,
  parameter int STARTUP_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              init_line,
  input  logic              prgm_n,
  input  logic              reset_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              master_mode,
  input  logic              cclk_en,
  input  logic              frame_done,
  input  logic [CNT_W-1:0]  len_count,
  input  logic              bit_err,
  input  logic              keep_mem,
  output logic              init_drv_low,
  output logic              hdc,
  output logic              ldc,
  output logic              done,
  output logic              io_active,
  output logic              int_rst_rel,
  output logic              mem_clear,
  output logic              cfg_active,
  output logic              op_active,
  output logic [MODE_W-1:0] mode_q
);
  localparam int HI_MAX = INIT_HI_CYC + MASTER_EXTRA;
  localparam int DLY_W  = $clog2(POR_CYC + 1);
  localparam int HI_W   = $clog2(HI_MAX + 1);
  localparam int SU_W   = $clog2(STARTUP_CYC + 1);

  typedef enum logic [1:0] {S_INIT, S_CFG, S_STUP, S_OPER} st_t;
  st_t st;

  logic [1:0] init_sy, prgm_sy, rst_sy;
  logic [DLY_W-1:0] dcnt;
  logic [HI_W-1:0]  hcnt;
  logic [SU_W-1:0]  sucnt;
  logic [CNT_W-1:0] cnt;
  logic frame_seen, cfg_once;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_sy <= '0;
      prgm_sy <= '0;
      rst_sy  <= '0;
    end else begin
      init_sy <= {init_sy[0], init_line};
      prgm_sy <= {prgm_sy[0], prgm_n};
      rst_sy  <= {rst_sy[0], reset_n};
    end

  wire init_s = init_sy[1];
  wire prgm_s = prgm_sy[1];
  wire rst_s  = rst_sy[1];

  wire [HI_W-1:0] need_hi = master_mode ? HI_W'(HI_MAX) : HI_W'(INIT_HI_CYC);
  wire dly_done  = dcnt == DLY_W'(POR_CYC);
  wire hi_ok     = dly_done && init_s && prgm_s && rst_s;
  wire go_cfg    = hi_ok && (hcnt == HI_W'(need_hi - 1'b1));
  wire cfg_full  = cnt == len_count;
  wire abort_cfg = !prgm_s || !rst_s || bit_err;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_INIT;
      dcnt       <= '0;
      hcnt       <= '0;
      sucnt      <= '0;
      cnt        <= '0;
      frame_seen <= 1'b0;
      cfg_once   <= 1'b0;
      mode_q     <= '0;
    end else begin
      case (st)
        S_INIT: begin
          if (pwr_good && !dly_done) dcnt <= dcnt + 1'b1;
          hcnt <= hi_ok ? hcnt + 1'b1 : '0;
          if (go_cfg) begin
            st         <= S_CFG;
            mode_q     <= mode_sel;
            cnt        <= '0;
            frame_seen <= 1'b0;
          end
        end
        S_CFG: begin
          if (abort_cfg) begin
            st   <= S_INIT;
            dcnt <= '0;
            hcnt <= '0;
          end else if (cfg_full && frame_seen) begin
            st       <= S_STUP;
            sucnt    <= '0;
            cfg_once <= 1'b1;
          end else begin
            if (cclk_en && !cfg_full) cnt <= cnt + 1'b1;
            if (frame_done) frame_seen <= 1'b1;
          end
        end
        S_STUP: begin
          if (!prgm_s) begin
            st   <= S_INIT;
            dcnt <= '0;
            hcnt <= '0;
          end else if (sucnt == SU_W'(STARTUP_CYC - 1)) st <= S_OPER;
          else sucnt <= sucnt + 1'b1;
        end
        default: begin
          if (!prgm_s) begin
            st   <= S_INIT;
            dcnt <= '0;
            hcnt <= '0;
          end
        end
      endcase
    end

  assign init_drv_low = (st == S_INIT) && !dly_done;
  assign hdc          = (st == S_INIT) || (st == S_CFG);
  assign ldc          = !hdc;
  assign done         = (st == S_STUP) || (st == S_OPER);
  assign io_active    = done;
  assign int_rst_rel  = done;
  assign cfg_active   = st == S_CFG;
  assign op_active    = st == S_OPER;
  assign mem_clear    = init_drv_low && (!cfg_once || !keep_mem);
endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
module cfg_seq_ctrl_chk #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cclk_en,
  input logic [CNT_W-1:0]  len_count,
  input logic [CNT_W-1:0]  cnt,
  input logic              frame_seen,
  input logic              prgm_s,
  input logic [MODE_W-1:0] mode_q,
  input logic              init_drv_low,
  input logic              cfg_active,
  input logic              done,
  input logic              op_active,
  input logic              io_active,
  input logic              int_rst_rel,
  input logic              hdc,
  input logic              ldc
);
  assert_drive_only_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_drv_low |-> (!done && !cfg_active && hdc));

  assert_done_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (io_active && int_rst_rel && ldc && !hdc));

  assert_op_has_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_active |-> done);

  assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> (cnt == '0));

  assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && !cclk_en) |=> (!cfg_active || $stable(cnt)));

  assert_finish_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt == len_count && frame_seen));

  assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && $past(cfg_active)) |-> $stable(mode_q));

  assert_prgm_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && !prgm_s) |=> !cfg_active);

  assert_reset_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && prgm_s) |=> done);
endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .len_count(len_count),
  .cnt(cnt), .frame_seen(frame_seen), .prgm_s(prgm_s), .mode_q(mode_q),
  .init_drv_low(init_drv_low), .cfg_active(cfg_active), .done(done),
  .op_active(op_active), .io_active(io_active), .int_rst_rel(int_rst_rel),
  .hdc(hdc), .ldc(ldc)
);

// File: tb/cfg_seq_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_tb_top;
  localparam int MODE_W = 3, CNT_W = 8, POR = 5, HI = 2, MX = 6, SU = 3;

  logic clk = 0, rst_n = 0, pwr_good = 0, ext_ok = 1, prgm_n = 1, reset_n = 1;
  logic [MODE_W-1:0] mode_sel = 3'd5;
  logic master_mode = 0, cclk_en = 0, frame_done = 0, bit_err = 0, keep_mem = 1;
  logic [CNT_W-1:0] len_count = 8'd6;
  logic init_drv_low, hdc, ldc, done, io_active, int_rst_rel, mem_clear, cfg_active, op_active;
  logic [MODE_W-1:0] mode_q;
  wire init_line = ext_ok & ~init_drv_low;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  cfg_seq_ctrl #(.MODE_W(MODE_W), .CNT_W(CNT_W), .POR_CYC(POR), .INIT_HI_CYC(HI),
                 .MASTER_EXTRA(MX), .STARTUP_CYC(SU)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .init_line(init_line),
    .prgm_n(prgm_n), .reset_n(reset_n), .mode_sel(mode_sel), .master_mode(master_mode),
    .cclk_en(cclk_en), .frame_done(frame_done), .len_count(len_count), .bit_err(bit_err),
    .keep_mem(keep_mem), .init_drv_low(init_drv_low), .hdc(hdc), .ldc(ldc), .done(done),
    .io_active(io_active), .int_rst_rel(int_rst_rel), .mem_clear(mem_clear),
    .cfg_active(cfg_active), .op_active(op_active), .mode_q(mode_q));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    case (w)
      0: return cfg_active;
      1: return done;
      2: return op_active;
      3: return !init_drv_low;
      4: return !cfg_active;
      default: return !done;
    endcase
  endfunction

  task automatic edges_until(input int w, output int n);
    n = 0;
    while (!sig(w) && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_cclk(input int k);
    cclk_en = 1;
    idle(k);
    cclk_en = 0;
  endtask

  task automatic pulse_frame();
    frame_done = 1;
    idle(1);
    frame_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    chk("R1 drive", init_drv_low, 1);
    chk("R1 hdc/ldc", {hdc, ldc}, 2'b10);
    chk("R1 quiet", {done, io_active, int_rst_rel, cfg_active, op_active}, 0);
    rst_n = 1;
    chk("R3 first clear", mem_clear, 1);
    idle(20);
    chk("R2 no power", init_drv_low, 1);
    pwr_good = 1;
    edges_until(3, n);
    chk("R2 delay", n, POR);
    edges_until(0, n);
    chk("R5 slave entry", n, 2 + HI);
    chk("R7 latch", mode_q, 5);
    mode_sel = 3'd2;
    idle(2);
    chk("R7 hold", mode_q, 5);
    pulse_frame();
    pulse_cclk(5);
    idle(5);
    chk("R8 short count", done, 0);
    pulse_cclk(1);
    edges_until(1, n);
    chk("R8 finish", n, 1);
    chk("R9 outputs", {hdc, ldc, io_active, int_rst_rel, op_active}, 5'b01110);
    edges_until(2, n);
    chk("R9 startup len", n, SU);
    reset_n = 0;
    idle(10);
    chk("R12 reset ignored", {done, op_active}, 2'b11);
    reset_n = 1;
    idle(3);
    prgm_n = 0;
    edges_until(5, n);
    chk("R12 prgm restart", n, 3);
    chk("R3 skip clear", {init_drv_low, mem_clear}, 2'b10);
    idle(20);
    chk("R10 prgm held", cfg_active, 0);
    prgm_n = 1;
    edges_until(0, n);
    chk("R10 reenter", n, 2 + HI);
    keep_mem = 0;
    reset_n = 0;
    edges_until(4, n);
    chk("R10 reset abort", n, 3);
    chk("R3 clear again", mem_clear, 1);
    idle(10);
    prgm_n = 0;
    reset_n = 1;
    idle(20);
    chk("R10 one still low", cfg_active, 0);
    prgm_n = 1;
    edges_until(0, n);
    chk("R10 both high", n, 2 + HI);
    bit_err = 1;
    idle(1);
    bit_err = 0;
    chk("R11 bit error", cfg_active, 0);
    ext_ok = 0;
    idle(30);
    chk("R4 line held", {cfg_active, init_drv_low}, 0);
    ext_ok = 1;
    edges_until(0, n);
    chk("R4 release", n, 2 + HI);
    keep_mem = 1;
    master_mode = 1;
    rst_n = 0;
    idle(2);
    rst_n = 1;
    chk("R3 power cycle clear", mem_clear, 1);
    edges_until(3, n);
    chk("R2 delay again", n, POR);
    edges_until(0, n);
    chk("R6 master entry", n, 2 + HI + MX);
    len_count = 8'd4;
    pulse_cclk(7);
    idle(3);
    chk("R8 no frame", done, 0);
    pulse_frame();
    edges_until(1, n);
    chk("R8 saturate", n, 1);
    idle(5);
    prgm_n = 0;
    idle(3);
    prgm_n = 1;
    edges_until(0, n);
    len_count = 8'd0;
    chk("R8 restart clear", done, 0);
    pulse_frame();
    edges_until(1, n);
    chk("R8 zero length", n, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule